// File: doc/BRIEF.md
# Two-Key Register Write-Lock Guard

This block sits beside the register file of a slow, always-powered timekeeping domain. It decides, for every host write, whether the write may land and which bits of the target word may change. A small set of configuration registers, and a few bit fields inside two shared registers, stay frozen until the host writes two unlock bytes in order to a dedicated key address. The first byte is 0xCA and the second is 0x53. Any other byte sent to the key address closes the lock again.

Each write request is qualified one cycle later. `wr_ok` says whether the register file should perform the write. `wr_mask` gives the bits it may update. The lock state lives in the persistent domain: the persistent-domain reset clears it, and the system reset leaves it alone. A domain-level enable input must be high before any write, including a key write, has an effect.

Top module: `wlk_guard`

## Requirements
- R1: After `pd_rst` the guard is locked: `unlocked`=0, and `wr_ok`=0 and `wr_mask`=0 in the cycle after reset.
- R2: A key write (address 7) of byte 0xCA followed by the next key write of byte 0x53 sets `unlocked`=1 on the clock edge that takes the second byte. Idle cycles and writes to other addresses between the two key writes do not break the sequence.
- R3: From the locked state, a key byte other than 0xCA leaves the guard locked. After 0xCA, a key byte that is neither 0x53 nor 0xCA returns it to locked, and a later 0x53 alone does not unlock.
- R4: Writing 0xCA again after 0xCA keeps the first stage, so the sequence 0xCA, 0xCA, 0x53 unlocks.
- R5: While unlocked, a key write of 0xCA drops `unlocked` and starts a new first stage. Any other key byte drops straight to locked.
- R6: `sys_rst` leaves `unlocked` unchanged. It forces `wr_ok`=0 and `wr_mask`=0 for the cycle after it is sampled.
- R7: With `dom_wr_en`=0 a request has no effect: `wr_ok`=0, `wr_mask`=0, and a key write does not move the lock state.
- R8: Writes to the fully protected addresses 0, 1, 4, 5 and 6 give `wr_ok`=0 and `wr_mask`=0 while locked, with no error indication. While unlocked they give `wr_ok`=1 and an all-ones mask.
- R9: Shared address 3 masks protected bits 0x00001F80, and shared address 2 masks protected bits 0x00030050. While locked, a write gives `wr_ok`=1 with those bits cleared in `wr_mask`. While unlocked, the mask is all ones.
- R10: Writes to any address not named in R8, R9 or R11 give `wr_ok`=1 and an all-ones mask whenever `dom_wr_en`=1, whatever the lock state.
- R11: Key writes are never forwarded to the register file: `wr_ok`=0 and `wr_mask`=0.
- R12: `wr_ok` and `wr_mask` are registered and reflect the request sampled on the previous edge. After a cycle with no request, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pd_rst | input | 1 | Persistent-domain reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| dom_wr_en | input | 1 | Domain-level write enable |
| wr_valid | input | 1 | Host write request |
| wr_addr | input | ADDR_W (4) | Word address of the write |
| wr_low_byte | input | 8 | Low byte of the write data, compared as a key |
| wr_ok | output | 1 | Registered: the write may be performed |
| wr_mask | output | DATA_W (32) | Registered: bits the write may update |
| unlocked | output | 1 | Lock state is open |

## Verification
The hardest state to reach from the ports is the first key stage. It has no output of its own, so the bench can only tell it apart from "locked" by what the next key byte does. The stimulus therefore reaches that stage by several routes: directly from locked, by a repeated 0xCA, and by 0xCA written while unlocked. It then probes the stage with 0x53, with a wrong byte, with a key write suppressed by `dom_wr_en`, and with a system reset placed in between. The scoreboard model predicts `unlocked` after each of these probes.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_e;

  typedef enum logic [2:0] {
    AC_OPEN = 3'd0,
    AC_FULL = 3'd1,
    AC_STAT = 3'd2,
    AC_CTRL = 3'd3,
    AC_KEY  = 3'd4
  } acls_e;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

endpackage

// File: rtl/wlk_key_fsm.sv
module wlk_key_fsm
  import wlk_pkg::*;
(
  input  logic      clk,
  input  logic      pd_rst,
  input  logic      key_wr,
  input  logic [7:0] key_byte,
  output lk_state_e state
);

  lk_state_e nxt;

  always_comb begin
    nxt = state;
    if (key_wr) begin
      unique case (state)
        LK_SHUT: nxt = (key_byte == KEY_FIRST) ? LK_HALF : LK_SHUT;
        LK_HALF: begin
          if (key_byte == KEY_SECOND)     nxt = LK_OPEN;
          else if (key_byte == KEY_FIRST) nxt = LK_HALF;
          else                            nxt = LK_SHUT;
        end
        LK_OPEN: nxt = (key_byte == KEY_FIRST) ? LK_HALF : LK_SHUT;
        default: nxt = LK_SHUT;
      endcase
    end
  end

  // Only the persistent-domain reset touches the lock state.
  always_ff @(posedge clk) begin
    if (pd_rst) state <= LK_SHUT;
    else        state <= nxt;
  end

  AST_OPEN_NEEDS_SECOND: assert property (@(posedge clk) disable iff (pd_rst)
    (state == LK_OPEN && $past(state) != LK_OPEN) |->
      ($past(key_wr) && $past(key_byte) == KEY_SECOND && $past(state) == LK_HALF)); // R2

  AST_BAD_BYTE_RELOCK: assert property (@(posedge clk) disable iff (pd_rst)
    (key_wr && state == LK_HALF && key_byte != KEY_SECOND && key_byte != KEY_FIRST)
      |=> state == LK_SHUT); // R3

  AST_REPEAT_FIRST_HOLD: assert property (@(posedge clk) disable iff (pd_rst)
    (key_wr && state == LK_HALF && key_byte == KEY_FIRST) |=> state == LK_HALF); // R4

  AST_OPEN_LEAVES: assert property (@(posedge clk) disable iff (pd_rst)
    (key_wr && state == LK_OPEN) |=> state != LK_OPEN); // R5

  AST_NO_KEY_HOLD: assert property (@(posedge clk) disable iff (pd_rst)
    !key_wr |=> $stable(state)); // R3

endmodule

// File: rtl/wlk_addr_dec.sv
module wlk_addr_dec
  import wlk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_FULL = 5,
  parameter logic [N_FULL*ADDR_W-1:0] FULL_LIST = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output acls_e             cls
);

  logic [N_FULL-1:0] hit;

  for (genvar gi = 0; gi < N_FULL; gi++) begin : g_full
    assign hit[gi] = (addr == FULL_LIST[gi*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    if (addr == KEY_ADDR)       cls = AC_KEY;
    else if (|hit)              cls = AC_FULL;
    else if (addr == STAT_ADDR) cls = AC_STAT;
    else if (addr == CTRL_ADDR) cls = AC_CTRL;
    else                        cls = AC_OPEN;
  end

endmodule

// File: rtl/wlk_gate.sv
module wlk_gate
  import wlk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] STAT_MASK = '0,
  parameter logic [DATA_W-1:0] CTRL_MASK = '0
) (
  input  logic              clk,
  input  logic              pd_rst,
  input  logic              sys_rst,
  input  logic              req,
  input  acls_e             cls,
  input  logic              open_now,
  output logic              wr_ok,
  output logic [DATA_W-1:0] wr_mask
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (pd_rst || sys_rst) begin
      wr_ok   <= 1'b0;
      wr_mask <= '0;
    end else begin
      wr_ok   <= 1'b0;
      wr_mask <= '0;
      if (req) begin
        unique case (cls)
          AC_KEY: ;
          AC_FULL: begin
            wr_ok   <= open_now;
            wr_mask <= open_now ? ALL_ONES : '0;
          end
          AC_STAT: begin
            wr_ok   <= 1'b1;
            wr_mask <= open_now ? ALL_ONES : ~STAT_MASK;
          end
          AC_CTRL: begin
            wr_ok   <= 1'b1;
            wr_mask <= open_now ? ALL_ONES : ~CTRL_MASK;
          end
          default: begin
            wr_ok   <= 1'b1;
            wr_mask <= ALL_ONES;
          end
        endcase
      end
    end
  end

  AST_FULL_LOCKED_DROP: assert property (@(posedge clk) disable iff (pd_rst || sys_rst)
    (req && cls == AC_FULL && !open_now) |=> (!wr_ok && wr_mask == '0)); // R8

  AST_SHARED_FIELDS_HELD: assert property (@(posedge clk) disable iff (pd_rst || sys_rst)
    (req && cls == AC_STAT && !open_now) |=> (wr_ok && (wr_mask & STAT_MASK) == '0)); // R9

  AST_KEY_NOT_FORWARDED: assert property (@(posedge clk) disable iff (pd_rst || sys_rst)
    (req && cls == AC_KEY) |=> !wr_ok); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (pd_rst || sys_rst)
    !req |=> (!wr_ok && wr_mask == '0)); // R12

endmodule

// File: rtl/wlk_guard.sv
module wlk_guard
  import wlk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_FULL = 5,
  parameter logic [N_FULL*ADDR_W-1:0] FULL_LIST = {4'd6, 4'd5, 4'd4, 4'd1, 4'd0},
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'd3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'd7,
  parameter logic [DATA_W-1:0] STAT_MASK = 32'h0000_1F80,
  parameter logic [DATA_W-1:0] CTRL_MASK = 32'h0003_0050
) (
  input  logic              clk,
  input  logic              pd_rst,
  input  logic              sys_rst,
  input  logic              dom_wr_en,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_low_byte,
  output logic              wr_ok,
  output logic [DATA_W-1:0] wr_mask,
  output logic              unlocked
);

  acls_e     cls;
  lk_state_e state;
  logic      req;
  logic      key_wr;

  assign req      = wr_valid && dom_wr_en;
  assign key_wr   = req && (cls == AC_KEY);
  assign unlocked = (state == LK_OPEN);

  wlk_addr_dec #(
    .ADDR_W(ADDR_W), .N_FULL(N_FULL), .FULL_LIST(FULL_LIST),
    .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR)
  ) i_dec (
    .addr(wr_addr),
    .cls (cls)
  );

  wlk_key_fsm i_fsm (
    .clk     (clk),
    .pd_rst  (pd_rst),
    .key_wr  (key_wr),
    .key_byte(wr_low_byte),
    .state   (state)
  );

  wlk_gate #(
    .DATA_W(DATA_W), .STAT_MASK(STAT_MASK), .CTRL_MASK(CTRL_MASK)
  ) i_gate (
    .clk     (clk),
    .pd_rst  (pd_rst),
    .sys_rst (sys_rst),
    .req     (req),
    .cls     (cls),
    .open_now(unlocked),
    .wr_ok   (wr_ok),
    .wr_mask (wr_mask)
  );

  AST_SYSRST_KEEPS_LOCK: assert property (@(posedge clk) disable iff (pd_rst)
    (sys_rst && !req) |=> $stable(unlocked)); // R6

  AST_DOMAIN_OFF_INERT: assert property (@(posedge clk) disable iff (pd_rst || sys_rst)
    (wr_valid && !dom_wr_en) |=> (!wr_ok && $stable(unlocked))); // R7

endmodule

// File: tb/test_wlk_guard.sv
module test_wlk_guard;

  logic        clk = 1'b0;
  logic        pd_rst = 1'b1;
  logic        sys_rst = 1'b0;
  logic        dom_wr_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_low_byte = '0;
  logic        wr_ok;
  logic [31:0] wr_mask;
  logic        unlocked;

  typedef struct {
    logic        ok;
    logic [31:0] mask;
    logic        unl;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  int    ms = 0;   // model: 0 locked, 1 first stage, 2 open

  wlk_guard i_wlk_guard (
    .clk(clk), .pd_rst(pd_rst), .sys_rst(sys_rst), .dom_wr_en(dom_wr_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_low_byte(wr_low_byte),
    .wr_ok(wr_ok), .wr_mask(wr_mask), .unlocked(unlocked)
  );

  always #10 clk = ~clk;

  task automatic cyc(input bit rp, input bit rs, input bit dom, input bit v,
                     input logic [3:0] a, input logic [7:0] b, input string tag);
    item_t it;
    bit    rq;
    @(negedge clk);
    pd_rst = rp; sys_rst = rs; dom_wr_en = dom; wr_valid = v;
    wr_addr = a; wr_low_byte = b;
    rq = v && dom;
    it.ok = 1'b0; it.mask = '0; it.tag = tag;
    if (!rp && !rs && rq) begin
      case (a)
        4'd7: ;
        4'd0, 4'd1, 4'd4, 4'd5, 4'd6: begin
          it.ok = (ms == 2); it.mask = (ms == 2) ? 32'hFFFF_FFFF : 32'h0;
        end
        4'd3: begin it.ok = 1'b1; it.mask = (ms == 2) ? 32'hFFFF_FFFF : ~32'h0000_1F80; end
        4'd2: begin it.ok = 1'b1; it.mask = (ms == 2) ? 32'hFFFF_FFFF : ~32'h0003_0050; end
        default: begin it.ok = 1'b1; it.mask = 32'hFFFF_FFFF; end
      endcase
    end
    if (rp) ms = 0;
    else if (rq && a == 4'd7) begin
      if (b == 8'hCA)                 ms = 1;
      else if (ms == 1 && b == 8'h53) ms = 2;
      else                            ms = 0;
    end
    it.unl = (ms == 2);
    q.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] b, input string tag);
    cyc(0, 0, 1, 1, a, b, tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 1, 0, 4'd0, 8'h00, tag);
  endtask

  // monitor: compares outputs 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (wr_ok !== e.ok) begin
          errors++;
          $display("FAIL %s wr_ok actual=%0b expected=%0b", e.tag, wr_ok, e.ok);
        end
        checks++;
        if (wr_mask !== e.mask) begin
          errors++;
          $display("FAIL %s wr_mask actual=%h expected=%h", e.tag, wr_mask, e.mask);
        end
        checks++;
        if (unlocked !== e.unl) begin
          errors++;
          $display("FAIL %s unlocked actual=%0b expected=%0b", e.tag, unlocked, e.unl);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(1, 0, 0, 0, 4'd0, 8'h00, "R1");
    cyc(1, 0, 1, 1, 4'd9, 8'h00, "R1");
    idle("R1");
    idle("R12");
    // locked-state behaviour of each address class
    wr(4'd0, 8'h00, "R8");
    wr(4'd5, 8'h00, "R8");
    wr(4'd3, 8'h00, "R9");
    wr(4'd2, 8'h00, "R9");
    wr(4'd9, 8'h00, "R10");
    wr(4'd7, 8'h11, "R11");
    wr(4'd7, 8'h53, "R3");
    // unlock with a gap and a foreign write between the bytes
    wr(4'd7, 8'hCA, "R2");
    idle("R2");
    wr(4'd9, 8'h53, "R2");
    wr(4'd7, 8'h53, "R2");
    wr(4'd0, 8'h00, "R8");
    wr(4'd6, 8'h00, "R8");
    wr(4'd3, 8'h00, "R9");
    wr(4'd2, 8'h00, "R9");
    wr(4'd15, 8'h00, "R10");
    wr(4'd7, 8'h00, "R11");   // relocks (R5)
    wr(4'd4, 8'h00, "R5");
    // system reset does not disturb the lock
    wr(4'd7, 8'hCA, "R2");
    wr(4'd7, 8'h53, "R2");
    cyc(0, 1, 1, 1, 4'd4, 8'h00, "R6");
    cyc(0, 1, 0, 0, 4'd0, 8'h00, "R6");
    wr(4'd4, 8'h00, "R6");
    // domain enable off
    cyc(0, 0, 0, 1, 4'd7, 8'h00, "R7");
    cyc(0, 0, 0, 1, 4'd9, 8'h00, "R7");
    wr(4'd1, 8'h00, "R7");
    // unlocked then 0xCA restarts at first stage
    wr(4'd7, 8'hCA, "R5");
    wr(4'd0, 8'h00, "R5");
    wr(4'd7, 8'h53, "R5");
    // repeated first byte
    wr(4'd7, 8'h53, "R5");
    wr(4'd7, 8'hCA, "R4");
    wr(4'd7, 8'hCA, "R4");
    wr(4'd7, 8'h53, "R4");
    // wrong byte after first stage
    wr(4'd7, 8'h00, "R3");
    wr(4'd7, 8'hCA, "R3");
    wr(4'd7, 8'h12, "R3");
    wr(4'd7, 8'h53, "R3");
    wr(4'd1, 8'h00, "R3");
    // first stage survives a suppressed key write and a system reset
    wr(4'd7, 8'hCA, "R7");
    cyc(0, 0, 0, 1, 4'd7, 8'h12, "R7");
    cyc(0, 1, 1, 0, 4'd0, 8'h00, "R6");
    wr(4'd7, 8'h53, "R7");
    wr(4'd3, 8'h00, "R9");
    // persistent reset relocks
    cyc(1, 0, 1, 1, 4'd7, 8'hCA, "R1");
    idle("R1");
    wr(4'd0, 8'h00, "R1");
    idle("R12");
    idle("R12");
    wait (q.size() == 0);
    @(posedge clk);
    #6;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule